// File: doc/BRIEF.md
# Dual-Register Inverting Bus Transceiver

This block passes 8-bit words between two bidirectional buses, A and B. Each direction owns a storage register with its own clock, an active-low clock enable and an active-low output enable. A word taken from one bus is stored inverted. It is then offered to the other bus.

Each bus is presented as three signals: the value sampled from the pins, the value to drive and a drive-enable flag. A pad wrapper outside the block merges them into a tri-state pin. The output enable only gates the drive flag and never touches the stored word. The two directions share nothing but the reset. If both directions drive at once, the block does not arbitrate between them.

Top module: `bxcvr_top`

## Requirements
- R1: There are two independent W-bit registers (W = 8 by default). The A-to-B register is shown on b_out and the B-to-A register is shown on a_out.
- R2: On a rising edge of clk_ab with ce_ab_n low and rst low, the A-to-B register loads. The same rule applies to clk_ba, ce_ba_n and the B-to-A register. The new value is visible on the output after that edge.
- R3: On a rising edge of a direction's clock with that direction's ce_n high, its register keeps its previous value.
- R4: The stored value is the bitwise inverse of the captured input. For example, 8'h00 is driven out as 8'hFF and 8'hA5 as 8'h5A.
- R5: b_oe is 1 exactly when oe_ab_n is 0 and rst is 0. a_oe is 1 exactly when oe_ba_n is 0 and rst is 0. A 0 on the flag means the pin is high impedance.
- R6: Changing oe_ab_n or oe_ba_n never alters the value on b_out or a_out.
- R7: Clock edges and enables of one direction have no effect on the register of the other direction.
- R8: Reset is synchronous and active high. At each clock edge of a direction while rst is 1, that register clears to all zeros. While rst is 1, both drive flags are 0 regardless of the output enables.
- R9: With both output enables low, a_oe and b_oe are both 1 and each output carries its own register. There is no arbitration between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Clock of the A-to-B register |
| clk_ba | input | 1 | Clock of the B-to-A register |
| rst | input | 1 | Synchronous active-high reset, applied to both registers |
| ce_ab_n | input | 1 | Active-low load enable, A to B |
| oe_ab_n | input | 1 | Active-low drive enable for bus B |
| ce_ba_n | input | 1 | Active-low load enable, B to A |
| oe_ba_n | input | 1 | Active-low drive enable for bus A |
| a_in | input | W | Value sampled from bus A |
| a_out | output | W | Value to drive on bus A (B-to-A register) |
| a_oe | output | 1 | Drive flag for bus A |
| b_in | input | W | Value sampled from bus B |
| b_out | output | W | Value to drive on bus B (A-to-B register) |
| b_oe | output | 1 | Drive flag for bus B |

## Verification
The two clocks run at the same rate with their rising edges 3 ns apart, so a fault that lets one direction follow the wrong clock shows up.

Directed words cover the inversion:
- all zeros and all ones, which expose a missing inversion;
- 8'hA5, which exposes swapped or shifted bits;
- different words on the two buses in the same cycle, which expose crossed paths.

Random words, clock enables and output enables are then mixed with reset pulses and compared against a reference model on every cycle. This separates load from hold, and drive gating from reset gating.

// File: rtl/bxcvr_pkg.sv
package bxcvr_pkg;

    localparam int BX_W     = 8;
    localparam int BX_PATHS = 2;

    // Index of each direction in the path array
    typedef enum logic {
        DIR_AB = 1'b0,
        DIR_BA = 1'b1
    } bx_dir_e;

    // Per-direction control set, all active low
    typedef struct packed {
        logic ld_n;
        logic drv_n;
    } bx_ctl_t;

    function automatic logic drive_flag(input logic drv_n, input logic rst);
        return !drv_n && !rst;
    endfunction

endpackage

// File: rtl/bxcvr_store.sv
module bxcvr_store #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] q_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= '0;
        end else if (!ld_n) begin
            q_r <= ~d;
        end
    end

    assign q = q_r;

endmodule

// File: rtl/bxcvr_drive.sv
module bxcvr_drive
    import bxcvr_pkg::*;
(
    input  logic rst,
    input  logic drv_n,
    output logic oe
);

    assign oe = drive_flag(drv_n, rst);

endmodule

// File: rtl/bxcvr_path.sv
module bxcvr_path
    import bxcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  bx_ctl_t      ctl,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         oe
);

    bxcvr_store #(.W(W)) store_i (
        .clk  (clk),
        .rst  (rst),
        .ld_n (ctl.ld_n),
        .d    (din),
        .q    (dout)
    );

    bxcvr_drive drive_i (
        .rst   (rst),
        .drv_n (ctl.drv_n),
        .oe    (oe)
    );

endmodule

// File: rtl/bxcvr_top.sv
module bxcvr_top
    import bxcvr_pkg::*;
#(
    parameter int W = BX_W
) (
    input  logic         clk_ab,
    input  logic         clk_ba,
    input  logic         rst,
    input  logic         ce_ab_n,
    input  logic         oe_ab_n,
    input  logic         ce_ba_n,
    input  logic         oe_ba_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe
);

    logic         p_clk  [BX_PATHS];
    bx_ctl_t      p_ctl  [BX_PATHS];
    logic [W-1:0] p_din  [BX_PATHS];
    logic [W-1:0] p_dout [BX_PATHS];
    logic         p_oe   [BX_PATHS];

    // Each direction samples one bus and feeds the opposite one
    assign p_clk[DIR_AB] = clk_ab;
    assign p_ctl[DIR_AB] = '{ld_n: ce_ab_n, drv_n: oe_ab_n};
    assign p_din[DIR_AB] = a_in;

    assign p_clk[DIR_BA] = clk_ba;
    assign p_ctl[DIR_BA] = '{ld_n: ce_ba_n, drv_n: oe_ba_n};
    assign p_din[DIR_BA] = b_in;

    for (genvar g = 0; g < BX_PATHS; g++) begin : g_path
        bxcvr_path #(.W(W)) path_i (
            .clk  (p_clk[g]),
            .rst  (rst),
            .ctl  (p_ctl[g]),
            .din  (p_din[g]),
            .dout (p_dout[g]),
            .oe   (p_oe[g])
        );
    end

    assign b_out = p_dout[DIR_AB];
    assign b_oe  = p_oe[DIR_AB];
    assign a_out = p_dout[DIR_BA];
    assign a_oe  = p_oe[DIR_BA];

endmodule

// File: rtl/bxcvr_checker.sv
module bxcvr_checker #(
    parameter int W = 8
) (
    input logic         clk_ab,
    input logic         clk_ba,
    input logic         rst,
    input logic         ce_ab_n,
    input logic         oe_ab_n,
    input logic         ce_ba_n,
    input logic         oe_ba_n,
    input logic [W-1:0] a_in,
    input logic [W-1:0] a_out,
    input logic         a_oe,
    input logic [W-1:0] b_in,
    input logic [W-1:0] b_out,
    input logic         b_oe
);

    // R2 R4: enabled edge stores the inverse of the bus value
    a_r2_load_ab: assert property (@(posedge clk_ab) disable iff (rst)
        !ce_ab_n |=> b_out == ~$past(a_in));
    a_r2_load_ba: assert property (@(posedge clk_ba) disable iff (rst)
        !ce_ba_n |=> a_out == ~$past(b_in));

    // R3: disabled edge keeps the register
    a_r3_hold_ab: assert property (@(posedge clk_ab) disable iff (rst)
        ce_ab_n |=> $stable(b_out));
    a_r3_hold_ba: assert property (@(posedge clk_ba) disable iff (rst)
        ce_ba_n |=> $stable(a_out));

    // R5: a high output enable leaves the bus undriven
    a_r5_off_ab: assert property (@(posedge clk_ab) oe_ab_n |-> !b_oe);
    a_r5_off_ba: assert property (@(posedge clk_ba) oe_ba_n |-> !a_oe);

    // R8: reset forces both drive flags off
    a_r8_rst_off: assert property (@(posedge clk_ab) rst |-> (!a_oe && !b_oe));

    // R8: register cleared after a reset edge
    a_r8_clear_ab: assert property (@(posedge clk_ab) rst |=> b_out == '0 || rst);

    // R9: both enables low drive both buses
    a_r9_both_on: assert property (@(posedge clk_ab) disable iff (rst)
        (!oe_ab_n && !oe_ba_n) |-> (a_oe && b_oe));

endmodule

bind bxcvr_top bxcvr_checker #(.W(W)) chk_i (
    .clk_ab  (clk_ab),
    .clk_ba  (clk_ba),
    .rst     (rst),
    .ce_ab_n (ce_ab_n),
    .oe_ab_n (oe_ab_n),
    .ce_ba_n (ce_ba_n),
    .oe_ba_n (oe_ba_n),
    .a_in    (a_in),
    .a_out   (a_out),
    .a_oe    (a_oe),
    .b_in    (b_in),
    .b_out   (b_out),
    .b_oe    (b_oe)
);

// File: tb/bxcvr_top_tb_top.sv
`timescale 1ns/1ps
module bxcvr_top_tb_top;

    localparam int W = 8;

    logic         clk_ab = 1'b0;
    logic         clk_ba = 1'b0;
    logic         rst = 1'b1;
    logic         ce_ab_n = 1'b1, oe_ab_n = 1'b1;
    logic         ce_ba_n = 1'b1, oe_ba_n = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] m_b = '0;
    logic [W-1:0] m_a = '0;

    // 125 MHz clocks, rising edges 3 ns apart
    always #4 clk_ab = ~clk_ab;
    initial begin
        #3;
        forever #4 clk_ba = ~clk_ba;
    end

    bxcvr_top #(.W(W)) dut_i (
        .clk_ab(clk_ab), .clk_ba(clk_ba), .rst(rst),
        .ce_ab_n(ce_ab_n), .oe_ab_n(oe_ab_n),
        .ce_ba_n(ce_ba_n), .oe_ba_n(oe_ba_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    function automatic logic [W-1:0] exp_store(input logic [W-1:0] cur, input logic [W-1:0] din,
                                               input logic ld_n, input logic r);
        if (r) return '0;
        if (!ld_n) return ~din;
        return cur;
    endfunction

    function automatic logic exp_flag(input logic en_n, input logic r);
        return (en_n == 1'b0) && (r == 1'b0);
    endfunction

    // Reference model, from R2 R3 R4 R8
    always @(posedge clk_ab) m_b <= exp_store(m_b, a_in, ce_ab_n, rst);
    always @(posedge clk_ba) m_a <= exp_store(m_a, b_in, ce_ba_n, rst);

    task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // Both clock edges fall between two calls; sample 1 ns after the B-to-A edge
    task automatic step();
        @(posedge clk_ba);
        #1;
    endtask

    task automatic check_model(input string tag);
        chk({tag, " b_out"}, b_out, m_b);
        chk({tag, " a_out"}, a_out, m_a);
        chk("R5 b_oe", {7'd0, b_oe}, {7'd0, exp_flag(oe_ab_n, rst)});
        chk("R5 a_oe", {7'd0, a_oe}, {7'd0, exp_flag(oe_ba_n, rst)});
    endtask

    initial begin : watchdog
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1357));
        oe_ab_n = 1'b0;
        oe_ba_n = 1'b0;
        ce_ab_n = 1'b0;
        ce_ba_n = 1'b0;
        a_in = 8'h3C;
        b_in = 8'hC3;
        repeat (3) step();
        // R8: cleared and undriven in reset
        chk("R8 b_out reset", b_out, 8'h00);
        chk("R8 a_out reset", a_out, 8'h00);
        chk("R8 b_oe reset", {7'd0, b_oe}, 8'h00);
        chk("R8 a_oe reset", {7'd0, a_oe}, 8'h00);

        rst = 1'b0;
        #0.1;
        chk("R9 both driven", {6'd0, a_oe, b_oe}, 8'h03);

        // R4: all zeros and all ones
        a_in = 8'h00; b_in = 8'hFF;
        step();
        chk("R4 b_out of 00", b_out, 8'hFF);
        chk("R4 a_out of FF", a_out, 8'h00);

        // R1 R4: distinct words on the two buses
        a_in = 8'hA5; b_in = 8'h81;
        step();
        chk("R1 R4 b_out of A5", b_out, 8'h5A);
        chk("R1 a_out of 81", a_out, 8'h7E);

        // R3: hold both
        ce_ab_n = 1'b1; ce_ba_n = 1'b1;
        a_in = 8'h11; b_in = 8'h22;
        step();
        chk("R3 b_out held", b_out, 8'h5A);
        chk("R3 a_out held", a_out, 8'h7E);

        // R6: output enables toggle, data unchanged
        oe_ab_n = 1'b1; oe_ba_n = 1'b1;
        step();
        chk("R6 b_out after oe off", b_out, 8'h5A);
        chk("R6 a_out after oe off", a_out, 8'h7E);
        chk("R5 flags off", {6'd0, a_oe, b_oe}, 8'h00);
        oe_ab_n = 1'b0;
        step();
        chk("R6 b_out after oe on", b_out, 8'h5A);
        chk("R5 only b driven", {6'd0, a_oe, b_oe}, 8'h01);

        // R7: only A-to-B loads
        ce_ab_n = 1'b0;
        a_in = 8'h0F; b_in = 8'h99;
        step();
        chk("R7 b_out loads", b_out, 8'hF0);
        chk("R7 a_out untouched", a_out, 8'h7E);

        // R7: only B-to-A loads
        ce_ab_n = 1'b1; ce_ba_n = 1'b0;
        a_in = 8'h55; b_in = 8'h0F;
        step();
        chk("R7 a_out loads", a_out, 8'hF0);
        chk("R7 b_out untouched", b_out, 8'hF0);

        // R2: random mix checked against the model
        for (int i = 0; i < 400; i++) begin
            a_in    = W'($urandom);
            b_in    = W'($urandom);
            ce_ab_n = 1'($urandom);
            ce_ba_n = 1'($urandom);
            oe_ab_n = 1'($urandom);
            oe_ba_n = 1'($urandom);
            rst     = (($urandom % 32) == 0);
            step();
            check_model("R2");
        end
        rst = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule